// File: doc/BRIEF.md
# Coherent Line-State Controller for a Snooping Write-Back Cache

This block keeps the coherence state of each line of a small direct-mapped write-back cache. The state is one of four: Modified (only copy, dirty), Exclusive (only copy, clean), Shared (clean, other caches may hold it) or Invalid. The block also holds the tag and data of every line in internal register files. It answers the local processor's reads and writes. When a request cannot be served from the line, it asks for the shared bus and runs one of four transactions: a plain read, a read-for-ownership, an ownership upgrade without data, or a write-back of a dirty victim.

At the same time the block watches transactions that other caches place on the bus. A matching snoop is resolved in the cycle it arrives. The block tells the requester whether a valid copy exists here. When required, it drives the line contents onto the bus for a cache-to-cache transfer, and it downgrades or invalidates the line.

Addresses are split, from the most significant bit down, into tag, line index and word offset. Bus and snoop addresses carry only tag and index.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. No bus request and no processor acknowledge are active, and no snoop at any address sees a copy.
- R2: A processor read that misses requests the bus with command 0 (plain read) and the line address. When the transaction completes, the line is filled from `bus_rdata`. It becomes Shared if `bus_shared_in` was high at completion and Exclusive otherwise, and the read is then served.
- R3: A processor write that misses on a non-Modified line requests command 1 (read-for-ownership). The fetched line becomes Modified and the written word is merged into it.
- R4: A write that hits a Shared line requests command 2 (upgrade) and the line becomes Modified without a data fetch. If a snoop invalidates the line while the request still waits for grant, the request turns into command 1.
- R5: Reads that hit in Exclusive, Shared or Modified, and writes that hit in Exclusive or Modified, are acknowledged in the cycle the request is presented, with no bus request. A write hit leaves the line Modified.
- R6: A snooped command 0 on an Exclusive or Modified line drives `snp_flush` with the line data on `snp_data` and leaves the line Shared. A snooped command 1 on such a line drives the data and leaves the line Invalid.
- R7: A snooped command 1 or 2 on a Shared line invalidates it. A snooped command 0 leaves it Shared. With `SHARED_SUPPLY` = 0 a Shared line never drives `snp_flush`.
- R8: Snoops to an Invalid line, snoops whose tag differs from the stored tag, and snoops with command 3 (write-back) produce no response and change no state.
- R9: `snp_shared` is high exactly when a snooped command 0 matches a valid line.
- R10: While a bus transaction is outstanding the processor is not acknowledged. `bus_req`, `bus_cmd` and `bus_addr` stay stable until `bus_gnt`, except for the conversion described in R4.
- R11: A snoop that matches the line at the processor's index takes priority in that cycle. The processor's local update or acknowledge for that cycle is dropped and the request is retried.
- R12: A miss whose index holds a Modified line with another tag first runs command 3, carrying the victim's address and data on `bus_wdata`. The line then becomes Invalid and the miss proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ack | output | 1 | Request served this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ack` |
| bus_req | output | 1 | Bus request, held until grant |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W-OFF_W | Line address {tag, index} |
| bus_wdata | output | (2**OFF_W)*DATA_W | Victim line for write-back |
| bus_gnt | input | 1 | Bus granted |
| bus_done | input | 1 | Transaction complete |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at done) |
| bus_rdata | input | (2**OFF_W)*DATA_W | Fill data at done |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W-OFF_W | Snooped line address |
| snp_shared | output | 1 | A valid copy exists here |
| snp_flush | output | 1 | Cache-to-cache data driven |
| snp_data | output | (2**OFF_W)*DATA_W | Line data for the transfer |

## Verification
The bench uses the default parameters: 8-bit addresses, four lines of two 8-bit words, and `SHARED_SUPPLY` = 0. With only four lines, conflict misses and dirty-victim write-backs occur after a handful of accesses. With shared supply turned off, a Shared line and an Exclusive line answer a snoop differently, so the fill outcome of R2 can be seen at the ports. The bench delays grant and injects snoops in the same cycle as processor requests. This reaches the upgrade-to-ownership conversion and the snoop-priority collision.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPGR = 2'd2, BC_WB = 2'd3} bus_op_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ASK = 2'd1, PH_WAIT = 2'd2} phase_e;

  // State a valid line takes after another cache's transaction.
  function automatic line_st_e snoop_next(line_st_e s, bus_op_e op);
    case (op)
      BC_RD:           return (s == ST_I) ? ST_I : ST_S;
      BC_RDX, BC_UPGR: return ST_I;
      default:         return s;
    endcase
  endfunction

  // Whether this copy must put its data on the bus.
  function automatic logic snoop_supplies(line_st_e s, bus_op_e op, logic s_may_supply);
    return ((op == BC_RD) || (op == BC_RDX)) &&
           ((s == ST_E) || (s == ST_M) || ((s == ST_S) && s_may_supply));
  endfunction

  // State of a freshly filled line.
  function automatic line_st_e fill_state(bus_op_e op, logic others_hold);
    if (op == BC_RD) return others_hold ? ST_S : ST_E;
    return ST_M;
  endfunction
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 5,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  localparam int LINES  = 1 << IDX_W,
  localparam int WORDS  = 1 << OFF_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [LINE_W-1:0] a_line,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [LINE_W-1:0] b_line,
  input  logic              s_we,
  input  line_st_e          s_st,
  input  logic              l_we_st,
  input  logic              l_we_fill,
  input  logic              l_we_word,
  input  line_st_e          l_st,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [LINE_W-1:0] l_line,
  input  logic [OFF_W-1:0]  l_off,
  input  logic [DATA_W-1:0] l_word
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES][WORDS];

  // Snoop write comes last so it wins on the same index (R11).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (l_we_st) st_q[a_idx] <= l_st;
      if (s_we)    st_q[b_idx] <= s_st;
    end
  end

  always_ff @(posedge clk) begin
    if (l_we_fill) begin
      tag_q[a_idx] <= l_tag;
      for (int w = 0; w < WORDS; w++) data_q[a_idx][w] <= l_line[w*DATA_W +: DATA_W];
    end
    if (l_we_word) data_q[a_idx][l_off] <= l_word;
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_pack
    assign a_line[w*DATA_W +: DATA_W] = data_q[a_idx][w];
    assign b_line[w*DATA_W +: DATA_W] = data_q[b_idx][w];
  end

  // R8: a snoop only ever rewrites a line that holds a copy.
  assert_snoop_needs_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> st_q[b_idx] != ST_I);

  // R11: the processor side never writes the index a snoop is rewriting.
  assert_no_local_under_snoop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && (a_idx == b_idx)) |-> !(l_we_st || l_we_fill || l_we_word));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int   TAG_W         = 5,
  parameter int   LINE_W        = 16,
  parameter logic SHARED_SUPPLY = 1'b0
) (
  input  logic              valid,
  input  bus_op_e           op,
  input  logic [TAG_W-1:0]  tag,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [LINE_W-1:0] ln_line,
  output logic              hit,
  output logic              we,
  output line_st_e          nxt,
  output logic              shared,
  output logic              flush,
  output logic [LINE_W-1:0] data
);
  always_comb begin
    hit    = valid && (ln_st != ST_I) && (ln_tag == tag);
    nxt    = snoop_next(ln_st, op);
    we     = hit && (nxt != ln_st);
    shared = hit && (op == BC_RD);
    flush  = hit && snoop_supplies(ln_st, op, SHARED_SUPPLY);
    data   = flush ? ln_line : '0;
  end
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  localparam int LINE_W = (1 << OFF_W) * DATA_W,
  localparam int LA_W   = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [TAG_W-1:0]  tag,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [LINE_W-1:0] ln_line,
  input  logic              collide,
  output logic              bus_req,
  output bus_op_e           bus_op,
  output logic [LA_W-1:0]   bus_laddr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              bus_shared,
  output logic              l_we_st,
  output logic              l_we_fill,
  output logic              l_we_word,
  output line_st_e          l_st,
  output logic [TAG_W-1:0]  l_tag
);
  phase_e            ph_q, ph_d;
  bus_op_e           op_q, op_d;
  logic [LA_W-1:0]   la_q, la_d;
  logic              tag_hit, serve, still_s;

  always_comb begin
    tag_hit   = (ln_st != ST_I) && (ln_tag == tag);
    serve     = tag_hit && (!we || (ln_st == ST_E) || (ln_st == ST_M));
    still_s   = tag_hit && (ln_st == ST_S);
    rdata     = ln_line[int'(off)*DATA_W +: DATA_W];
    ack       = 1'b0;
    bus_req   = 1'b0;
    bus_op    = op_q;
    l_we_st   = 1'b0;
    l_we_fill = 1'b0;
    l_we_word = 1'b0;
    l_st      = ST_I;
    l_tag     = la_q[LA_W-1:IDX_W];
    ph_d      = ph_q;
    op_d      = op_q;
    la_d      = la_q;
    case (ph_q)
      PH_IDLE: if (req && !collide) begin
        if (serve) begin
          ack = 1'b1;
          if (we) begin                          // R5: E or M write hit ends Modified
            l_we_st   = 1'b1;
            l_st      = ST_M;
            l_we_word = 1'b1;
          end
        end else begin
          ph_d = PH_ASK;
          la_d = {tag, idx};
          if (tag_hit)            op_d = BC_UPGR;   // R4
          else if (ln_st == ST_M) begin             // R12: dirty victim first
            op_d = BC_WB;
            la_d = {ln_tag, idx};
          end else op_d = we ? BC_RDX : BC_RD;      // R2, R3
        end
      end
      PH_ASK: begin
        bus_req = 1'b1;
        if ((op_q == BC_UPGR) && !still_s) bus_op = BC_RDX;  // R4 conversion
        op_d = bus_op;
        if (bus_gnt) ph_d = PH_WAIT;
      end
      PH_WAIT: if (bus_done) begin
        ph_d = PH_IDLE;
        if (!collide) begin
          case (op_q)
            BC_WB:   begin l_we_st = 1'b1; l_st = ST_I; end
            BC_UPGR: begin l_we_st = 1'b1; l_st = ST_M; end
            default: begin
              l_we_fill = 1'b1;
              l_we_st   = 1'b1;
              l_st      = fill_state(op_q, bus_shared);
            end
          endcase
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    bus_laddr = la_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      op_q <= BC_RD;
      la_q <= '0;
    end else begin
      ph_q <= ph_d;
      op_q <= op_d;
      la_q <= la_d;
    end
  end

  // R10: an ungranted request stays up with the same line address.
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_laddr)));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int   ADDR_W        = 8,
  parameter int   IDX_W         = 2,
  parameter int   OFF_W         = 1,
  parameter int   DATA_W        = 8,
  parameter logic SHARED_SUPPLY = 1'b0,
  localparam int  TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int  LADDR_W = ADDR_W - OFF_W,
  localparam int  LINE_W  = (1 << OFF_W) * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ack,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               bus_req,
  output logic [1:0]         bus_cmd,
  output logic [LADDR_W-1:0] bus_addr,
  output logic [LINE_W-1:0]  bus_wdata,
  input  logic               bus_gnt,
  input  logic               bus_done,
  input  logic               bus_shared_in,
  input  logic [LINE_W-1:0]  bus_rdata,
  input  logic               snp_valid,
  input  logic [1:0]         snp_cmd,
  input  logic [LADDR_W-1:0] snp_addr,
  output logic               snp_shared,
  output logic               snp_flush,
  output logic [LINE_W-1:0]  snp_data
);
  logic [TAG_W-1:0]  c_tag, s_tag, a_tag, b_tag, l_tag;
  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [OFF_W-1:0]  c_off;
  line_st_e          a_st, b_st, s_nxt, l_st;
  logic [LINE_W-1:0] a_line, b_line;
  logic              s_hit, s_we, collide;
  logic              l_we_st, l_we_fill, l_we_word;
  bus_op_e           op;

  assign {c_tag, c_idx, c_off} = cpu_addr;
  assign {s_tag, s_idx}        = snp_addr;
  assign collide               = s_hit && (s_idx == c_idx);   // R11
  assign bus_cmd               = op;
  assign bus_wdata             = a_line;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_line(a_line),
    .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag), .b_line(b_line),
    .s_we(s_we), .s_st(s_nxt),
    .l_we_st(l_we_st), .l_we_fill(l_we_fill), .l_we_word(l_we_word),
    .l_st(l_st), .l_tag(l_tag), .l_line(bus_rdata), .l_off(c_off), .l_word(cpu_wdata)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .LINE_W(LINE_W), .SHARED_SUPPLY(SHARED_SUPPLY)) u_snoop (
    .valid(snp_valid), .op(bus_op_e'(snp_cmd)), .tag(s_tag),
    .ln_st(b_st), .ln_tag(b_tag), .ln_line(b_line),
    .hit(s_hit), .we(s_we), .nxt(s_nxt),
    .shared(snp_shared), .flush(snp_flush), .data(snp_data)
  );

  mesi_cpu_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req(cpu_req), .we(cpu_we), .tag(c_tag), .idx(c_idx), .off(c_off),
    .ack(cpu_ack), .rdata(cpu_rdata),
    .ln_st(a_st), .ln_tag(a_tag), .ln_line(a_line), .collide(collide),
    .bus_req(bus_req), .bus_op(op), .bus_laddr(bus_addr),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared(bus_shared_in),
    .l_we_st(l_we_st), .l_we_fill(l_we_fill), .l_we_word(l_we_word),
    .l_st(l_st), .l_tag(l_tag)
  );

  // R4: an upgrade is only ever offered for a line still held Shared.
  assert_upgrade_from_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_cmd == 2'd2)) |-> ((a_st == ST_S) && (a_tag == c_tag)));

  // R9: the presence indication only answers a plain read.
  assert_shared_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && (snp_cmd == 2'd0)));
endmodule

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [7:0]  cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_ack;
  logic [7:0]  cpu_rdata;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [6:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_gnt = 0, bus_done = 0, bus_shared_in = 0;
  logic [15:0] bus_rdata = 0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = 0;
  logic [6:0]  snp_addr = 0;
  logic        snp_shared, snp_flush;
  logic [15:0] snp_data;

  int n_vec = 0, n_fail = 0, n_cyc = 0;

  // Reference model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  int          m_st [4];
  logic [4:0]  m_tag [4];
  logic [15:0] m_line [4];
  logic [15:0] mem [128];

  always #4 clk = ~clk;

  mesi_line_ctrl i_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [6:0] la);
    return (m_st[la[1:0]] != 0) && (m_tag[la[1:0]] == la[6:2]);
  endfunction

  function automatic void m_snoop(input logic [1:0] c, input logic [6:0] la);
    if (m_hit(la) && c != 2'd3) m_st[la[1:0]] = (c == 2'd0) ? 1 : 0;
  endfunction

  // Snoop response compared on every clock against the model
  always @(posedge clk) begin
    int si; bit h, esh, efl; string rq;
    if (rst_n && snp_valid) begin
      si  = int'(snp_addr[1:0]);
      h   = m_hit(snp_addr);
      esh = h && snp_cmd == 2'd0;
      efl = h && m_st[si] >= 2 && snp_cmd <= 2'd1;
      rq  = !h ? "R8" : (m_st[si] == 1 ? "R7" : "R6");
      chk(snp_shared == esh, "R9", "snp_shared", snp_shared, esh);
      chk(snp_flush == efl, rq, "snp_flush", snp_flush, efl);
      if (efl) chk(snp_data == m_line[si], rq, "snp_data", snp_data, m_line[si]);
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      chk(0, "R10", "watchdog expired", n_cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic snoop(input logic [1:0] c, input logic [6:0] la);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = la;
    @(posedge clk);
    @(negedge clk);
    m_snoop(c, la);
    snp_valid = 0;
  endtask

  // inj: 0 none, 1 snoop in the first request cycle, 2 snoop in first cycle bus_req is up (grant withheld)
  task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd, input bit shr,
                        input int inj, input logic [1:0] ic, input logic [6:0] ila);
    logic [4:0] tg; int ix; int of; bit hit, srv, col, doi, injd, held; int eop; logic [6:0] ela;
    tg = a[7:3]; ix = int'(a[2:1]); of = int'(a[0]);
    injd = 0; held = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int cyc = 0; cyc < 40; cyc++) begin
      #1;
      hit = m_hit(a[7:1]);
      srv = hit && (!we || m_st[ix] >= 2);
      doi = !injd && ((inj == 1 && cyc == 0) || (inj == 2 && bus_req));
      col = 0;
      if (doi) begin
        injd = 1; snp_valid = 1; snp_cmd = ic; snp_addr = ila;
        col = m_hit(ila) && (ila[1:0] == a[2:1]);
        #1;
      end
      if (cyc == 0)
        chk(cpu_ack == (srv && !col), col ? "R11" : "R5", "ack in request cycle", cpu_ack, srv && !col);
      if (cpu_ack) begin
        chk(!bus_req, "R10", "bus_req with ack", bus_req, 0);
        if (!we) chk(cpu_rdata == m_line[ix][of*8 +: 8], "R5", "read data", cpu_rdata, m_line[ix][of*8 +: 8]);
        @(posedge clk); @(negedge clk);
        if (we) begin m_line[ix][of*8 +: 8] = wd; m_st[ix] = 3; end
        cpu_req = 0;
        return;
      end
      if (bus_req) begin
        eop = hit ? 2 : (m_st[ix] == 3 ? 3 : (we ? 1 : 0));
        ela = (eop == 3) ? {m_tag[ix], a[2:1]} : a[7:1];
        chk(bus_cmd == 2'(eop), eop == 0 ? "R2" : eop == 1 ? "R3" : eop == 2 ? "R4" : "R12",
            "bus_cmd", bus_cmd, eop);
        chk(bus_addr == ela, "R12", "bus_addr", bus_addr, ela);
        if (eop == 3) chk(bus_wdata == m_line[ix], "R12", "victim data", bus_wdata, m_line[ix]);
        if (doi) begin
          @(posedge clk); @(negedge clk);
          m_snoop(ic, ila); snp_valid = 0; held = 1;
          continue;
        end
        if (!held) begin
          held = 1;
          @(posedge clk); @(negedge clk); #1;
          chk(bus_req && bus_cmd == 2'(eop) && bus_addr == ela, "R10", "request held",
              {bus_req, bus_cmd}, {1'b1, 2'(eop)});
          chk(!cpu_ack, "R10", "ack while waiting", cpu_ack, 0);
        end
        bus_gnt = 1;
        @(posedge clk); @(negedge clk);
        bus_gnt = 0; bus_done = 1; bus_shared_in = shr; bus_rdata = mem[ela];
        #1 chk(!cpu_ack, "R10", "ack during transfer", cpu_ack, 0);
        @(posedge clk); @(negedge clk);
        bus_done = 0;
        case (eop)
          3: begin mem[ela] = m_line[ix]; m_st[ix] = 0; end
          2: m_st[ix] = 3;
          default: begin m_tag[ix] = tg; m_line[ix] = mem[ela]; m_st[ix] = (eop == 0) ? (shr ? 1 : 2) : 3; end
        endcase
        held = 0;
        continue;
      end
      @(posedge clk); @(negedge clk);
      if (doi) begin m_snoop(ic, ila); snp_valid = 0; end
    end
    chk(0, "R10", "request never completed", 0, 1);
    cpu_req = 0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i) + 8'h11};
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; m_line[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!bus_req, "R1", "bus_req after reset", bus_req, 0);
    chk(!cpu_ack, "R1", "cpu_ack after reset", cpu_ack, 0);
    snoop(2'd0, 7'h08);                       // R1: nothing held
    snoop(2'd1, 7'h33);
    access(0, 8'h10, 0, 0, 0, 0, 0);          // R2 read miss -> Exclusive
    access(0, 8'h11, 0, 0, 0, 0, 0);          // R5 read hit
    snoop(2'd0, 7'h08);                       // R6 E + read -> flush, Shared
    access(1, 8'h10, 8'h3C, 0, 0, 0, 0);      // R4 upgrade
    access(0, 8'h10, 0, 0, 0, 0, 0);          // R5 read in Modified
    snoop(2'd1, 7'h08);                       // R6 M + RdX -> flush, Invalid
    snoop(2'd0, 7'h08);                       // R8 now Invalid
    access(1, 8'h22, 8'h77, 0, 0, 0, 0);      // R3 write miss
    access(1, 8'h23, 8'h99, 0, 0, 0, 0);      // R5 write hit in M
    access(0, 8'h22, 0, 0, 0, 0, 0);          // R3 merged word
    snoop(2'd3, 7'h11);                       // R8 write-back command ignored
    snoop(2'd0, 7'h31);                       // R8 tag mismatch
    access(0, 8'h62, 0, 1, 0, 0, 0);          // R12 evict dirty, then R2 -> Shared
    snoop(2'd0, 7'h31);                       // R7 stays Shared, no flush
    snoop(2'd2, 7'h31);                       // R7 upgrade invalidates
    snoop(2'd0, 7'h31);                       // R8
    access(0, 8'h22, 0, 0, 0, 0, 0);          // written-back data returns
    access(0, 8'h04, 0, 1, 0, 0, 0);          // Shared at index 2
    access(1, 8'h04, 8'h5E, 0, 2, 2'd1, 7'h02); // R4 conversion to RdX
    snoop(2'd0, 7'h02);                       // R6 M -> S
    access(0, 8'h06, 0, 0, 0, 0, 0);          // Exclusive at index 3
    access(1, 8'h06, 8'hA1, 0, 1, 2'd0, 7'h03); // R11 collision, then upgrade
    access(0, 8'h40, 0, 0, 0, 0, 0);          // Exclusive at index 0
    snoop(2'd1, 7'h20);                       // R6 E + RdX -> Invalid
    access(0, 8'h07, 0, 0, 1, 2'd0, 7'h13);   // R5 unrelated snoop does not block
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule